// File: doc/BRIEF.md
# Read-Only I2C Result Target

This block is the I2C target end of a converter that only ever gets read. A controller on the bus sends a START, then a 7-bit address and a direction bit. The block samples SCL and SDA with its own fast system clock and detects START, repeated START and STOP from those samples. It checks the address against one of two fixed values, picked by a strap input. It then acknowledges or refuses depending on whether a conversion is still running.

Once it has acknowledged, the block copies the 16-bit result into a shift register. It sends the result as two bytes, most significant bit first, and drives SDA through an active-high pull-down enable. The controller acknowledges the high byte and not-acknowledges the low byte. A single-cycle `read_done` pulse marks the end of the output phase, so that the surrounding logic can start the next conversion.

Top module: `i2c_result_target`

## Requirements
- R1: After reset, `sda_drive_low` is 0 and `read_done` is 0 until a transfer is addressed.
- R2: A START (SDA falling while SCL is high) and a STOP (SDA rising while SCL is high) are recognised only while SCL is high. SDA changes while SCL is low are treated as data and never as bus conditions.
- R3: The target address is 7'b0010100 when `addr_sel` is 0 and 7'b1010100 when `addr_sel` is 1. The address is sent MSB first and is followed by the direction bit, where 1 means read. A different address, or a direction bit of 0, gets a NAK (SDA left released). The block then ignores the bus until the next START.
- R4: A matching read while `conv_busy` is 1 gets a NAK. The block then drives nothing and produces no `read_done` for that transfer.
- R5: A matching read while `conv_busy` is 0 gets an ACK: SDA is held low through the ninth SCL clock.
- R6: After the ACK, the 16 result bits go out MSB first (D15 down to D0) as two 8-bit groups. The drive changes only after a falling SCL edge, never while SCL is high.
- R7: The result is captured at the moment of the ACK decision. Later changes to `result` do not affect the bits being sent.
- R8: A controller ACK (SDA low) in the ninth clock after the high byte makes the low byte follow. A controller NACK there ends the output phase, and the low byte then reads as all ones.
- R9: At the falling SCL edge that ends the ninth clock after the low byte, `read_done` pulses for exactly one cycle and SDA is released.
- R10: A STOP during the output phase ends it at once with a one-cycle `read_done` pulse, and SDA is released.
- R11: A repeated START at any point releases SDA and restarts address reception, exactly like a first START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| addr_sel | input | 1 | Strap that picks one of the two bus addresses |
| conv_busy | input | 1 | 1 while a conversion is running |
| result | input | 16 | Latest conversion result |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| read_done | output | 1 | One-cycle pulse when the output phase ends |

## Verification
A wrong address decode, or a wrong reading of the busy flag, shows as a wrong acknowledge level in the ninth SCL clock of the same transfer. A bit counter or shift register that is off by one shows as a wrong data bit in the first affected byte. If the output phase ends at the wrong point, either the pulse count on `read_done` is wrong or the line stays low where the controller expects ones. The synchroniser and edge stages add about three system clocks between an SCL edge and the change on `sda_drive_low`. Every fault therefore shows within one SCL period of its cause.

// File: rtl/irt_pkg.sv
// Package: shared state type and address helper for the read-only I2C result target.
// Assumes 7-bit addressing and 8-bit bus groups.
package irt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for a START
        ST_ADDR,     // shifting in address and direction
        ST_ACK,      // holding SDA low in the ninth clock
        ST_DATA,     // presenting result bits
        ST_HOST_ACK  // controller drives the ninth bit
    } irt_state_t;

    // Pick the bus address from the strap value.
    function automatic logic [6:0] pick_addr(input logic sel,
                                             input logic [6:0] a_lo,
                                             input logic [6:0] a_hi);
        return sel ? a_hi : a_lo;
    endfunction

endpackage

// File: rtl/irt_sync.sv
// Module: multi-stage synchroniser for asynchronous line inputs.
// Assumes each bit is independent; resets to RESET_VAL (idle bus is high).
module irt_sync #(
    parameter int         WIDTH     = 2,
    parameter int         STAGES    = 2,
    parameter logic       RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through the register chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d_in[b]};
        end

        assign d_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/irt_bus_cond.sv
// Module: edge and bus-condition detector on synchronised SCL/SDA.
// Assumes both inputs come through synchronisers of equal depth.
module irt_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q, sda_q;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Decode edges and START/STOP from the current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/irt_read_fsm.sv
// Module: address check, acknowledge and result shifter for a read-only target.
// Assumes edges and conditions are single-cycle strobes; a STOP outranks a START.
module irt_read_fsm
    import irt_pkg::*;
#(
    parameter int         DATA_W  = 16,
    parameter logic [6:0] ADDR_LO = 7'b0010100,
    parameter logic [6:0] ADDR_HI = 7'b1010100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel,
    input  logic              conv_busy,
    input  logic [DATA_W-1:0] result,
    output logic              drive_low,
    output logic              done
);

    localparam int NBYTES = DATA_W / 8;
    localparam int BYTE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(NBYTES - 1);

    irt_state_t        state;
    logic [7:0]        in_sr;
    logic [3:0]        in_cnt;
    logic [DATA_W-1:0] out_sr;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] byte_cnt;
    logic              host_ack;
    logic              addr_hit;

    // Compare the received address with the strap-selected one.
    assign addr_hit = (in_sr[7:1] == pick_addr(addr_sel, ADDR_LO, ADDR_HI));

    // Sequence address reception, acknowledge and data output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            in_sr     <= '0;
            in_cnt    <= '0;
            out_sr    <= '0;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            host_ack  <= 1'b0;
            drive_low <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (stop_det) begin
                if (state inside {ST_ACK, ST_DATA, ST_HOST_ACK}) done <= 1'b1;
                state     <= ST_IDLE;
                drive_low <= 1'b0;
            end else if (start_det) begin
                state     <= ST_ADDR;
                in_cnt    <= '0;
                drive_low <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise && in_cnt < 4'd8) begin
                            in_sr  <= {in_sr[6:0], sda_s};
                            in_cnt <= in_cnt + 4'd1;
                        end else if (scl_fall && in_cnt == 4'd8) begin
                            if (addr_hit && in_sr[0] && !conv_busy) begin
                                drive_low <= 1'b1;
                                out_sr    <= result;
                                state     <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            drive_low <= ~out_sr[DATA_W-1];
                            bit_cnt   <= '0;
                            byte_cnt  <= '0;
                            state     <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (scl_fall) begin
                            out_sr  <= out_sr << 1;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                drive_low <= 1'b0;
                                state     <= ST_HOST_ACK;
                            end else begin
                                drive_low <= ~out_sr[DATA_W-2];
                            end
                        end
                    end
                    ST_HOST_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (host_ack && byte_cnt != LAST_BYTE) begin
                                byte_cnt  <= byte_cnt + 1'b1;
                                bit_cnt   <= '0;
                                drive_low <= ~out_sr[DATA_W-1];
                                state     <= ST_DATA;
                            end else begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_result_target.sv
// Module: top of the read-only I2C result target.
// Assumes the system clock is at least eight times the SCL rate and an external pull-up on SDA.
module i2c_result_target #(
    parameter int         DATA_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_LO     = 7'b0010100,
    parameter logic [6:0] ADDR_HI     = 7'b1010100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              addr_sel,
    input  logic              conv_busy,
    input  logic [DATA_W-1:0] result,
    output logic              sda_drive_low,
    output logic              read_done
);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    irt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out ({scl_s, sda_s})
    );

    irt_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    irt_read_fsm #(.DATA_W(DATA_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .conv_busy (conv_busy),
        .result    (result),
        .drive_low (sda_drive_low),
        .done      (read_done)
    );

endmodule

// File: rtl/irt_checker.sv
// Module: protocol checker bound to the result target top.
// Assumes it observes the synchronised SCL and the detector strobes of the top.
module irt_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_drive_low,
    input logic read_done
);

    // R6: the drive never changes while synchronised SCL stays high
    a_r6_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_drive_low));

    // R9: the end pulse lasts a single cycle
    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |=> !read_done);

    // R9: the line is released when the output phase ends
    a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |-> !sda_drive_low);

    // R10: a STOP releases the line on the next cycle
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low);

    // R11: a START or repeated START releases the line on the next cycle
    a_r11_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_drive_low);

endmodule

bind i2c_result_target irt_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_s         (scl_s),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sda_drive_low (sda_drive_low),
    .read_done     (read_done)
);

// File: tb/i2c_result_target_bench.sv
// Bench: bit-level I2C controller model with directed and seeded random reads.
module i2c_result_target_bench;

    localparam int H = 12;
    localparam logic [6:0] A_LO = 7'b0010100;
    localparam logic [6:0] A_HI = 7'b1010100;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, scl_ctrl, sda_ctrl, addr_sel, conv_busy;
    logic [15:0] result;
    logic        sda_drive_low, read_done;
    wire         sda_line = sda_ctrl & ~sda_drive_low;

    i2c_result_target u_i2c_result_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_ctrl),
        .sda_in        (sda_line),
        .addr_sel      (addr_sel),
        .conv_busy     (conv_busy),
        .result        (result),
        .sda_drive_low (sda_drive_low),
        .read_done     (read_done)
    );

    int checks = 0, failures = 0, done_cnt = 0, wide_cnt = 0;
    logic done_prev = 1'b0;

    // Count end pulses and flag any pulse longer than one cycle.
    always @(posedge clk) begin
        if (rst_n && read_done) done_cnt++;
        if (rst_n && read_done && done_prev) wide_cnt++;
        done_prev = read_done;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_ack(input logic [6:0] a, input logic rw,
                                     input logic sel, input logic busy);
        return rw && !busy && (a == (sel ? A_HI : A_LO));
    endfunction

    function automatic logic [15:0] exp_data(input logic ack, input logic [15:0] r,
                                             input logic hack);
        if (!ack) return 16'hFFFF;
        return hack ? r : {r[15:8], 8'hFF};
    endfunction

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_ctrl = 1'b0; half();
        scl_ctrl = 1'b0; half();
    endtask

    task automatic bus_rstart();
        sda_ctrl = 1'b1; half();
        scl_ctrl = 1'b1; half();
        sda_ctrl = 1'b0; half();
        scl_ctrl = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_ctrl = 1'b0; half();
        scl_ctrl = 1'b1; half();
        sda_ctrl = 1'b1; half();
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_ctrl = b; half();
        scl_ctrl = 1'b1;
        repeat (H/2) @(negedge clk);
        s = sda_line;
        repeat (H/2) @(negedge clk);
        scl_ctrl = 1'b0; half();
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, output logic acked);
        logic s;
        for (int i = 6; i >= 0; i--) bit_io(a[i], s);
        bit_io(rw, s);
        bit_io(1'b1, s);
        acked = !s;
    endtask

    task automatic read_bytes(input logic hack, output logic [15:0] d);
        logic s;
        for (int i = 15; i >= 8; i--) bit_io(1'b1, d[i]);
        bit_io(!hack, s);
        for (int i = 7; i >= 0; i--) bit_io(1'b1, d[i]);
        bit_io(1'b1, s);
    endtask

    // Full read transfer with optional result change right after the ACK slot.
    task automatic read_txn(input string tag, input logic [6:0] a, input logic rw,
                            input logic hack, input logic swap, input logic glitch);
        logic        acked, e_ack;
        logic [15:0] d, r0;
        int          d0;
        d0    = done_cnt;
        r0    = result;
        e_ack = exp_ack(a, rw, addr_sel, conv_busy);
        bus_start();
        if (glitch) begin
            sda_ctrl = 1'b1; half();
            sda_ctrl = 1'b0; half();
            sda_ctrl = 1'b1; half();
        end
        send_addr(a, rw, acked);
        if (swap) result = ~result;
        read_bytes(hack, d);
        bus_stop();
        half();
        check({tag, " ack"}, 32'(acked), 32'(e_ack));
        check({tag, " data"}, 32'(d), 32'(exp_data(e_ack, r0, hack)));
        check({tag, " done count"}, 32'(done_cnt - d0), e_ack ? 32'd1 : 32'd0);
        check({tag, " released"}, 32'(sda_drive_low), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic        acked, s;
        logic [3:0]  nib;
        int          d0;
        void'($urandom(32'd1234));
        rst_n = 1'b0; scl_ctrl = 1'b1; sda_ctrl = 1'b1;
        addr_sel = 1'b0; conv_busy = 1'b0; result = 16'h0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        half();
        check("R1 reset drive", 32'(sda_drive_low), 32'd0);
        check("R1 reset done", 32'(done_cnt), 32'd0);

        result = 16'h5A3C;
        read_txn("R5 R6 strap0 read", A_LO, 1'b1, 1'b1, 1'b0, 1'b0);
        addr_sel = 1'b1; result = 16'hC3A5;
        read_txn("R3 strap1 read", A_HI, 1'b1, 1'b1, 1'b0, 1'b0);
        read_txn("R3 other strap address", A_LO, 1'b1, 1'b1, 1'b0, 1'b0);
        read_txn("R3 write request", A_HI, 1'b0, 1'b1, 1'b0, 1'b0);
        conv_busy = 1'b1;
        read_txn("R4 busy nak", A_HI, 1'b1, 1'b1, 1'b0, 1'b0);
        conv_busy = 1'b0; addr_sel = 1'b0; result = 16'hA5C3;
        read_txn("R7 result change after ack", A_LO, 1'b1, 1'b1, 1'b1, 1'b0);
        result = 16'h1E77;
        read_txn("R8 controller nack high byte", A_LO, 1'b1, 1'b0, 1'b0, 1'b0);
        result = 16'h0001;
        read_txn("R2 sda toggles with scl low", A_LO, 1'b1, 1'b1, 1'b0, 1'b1);

        // R10: STOP after four data bits ends the output phase.
        result = 16'h5A3C;
        d0 = done_cnt;
        bus_start();
        send_addr(A_LO, 1'b1, acked);
        for (int i = 3; i >= 0; i--) bit_io(1'b1, nib[i]);
        check("R10 ack before stop", 32'(acked), 32'd1);
        check("R10 first nibble", 32'(nib), 32'h5);
        bus_stop();
        half();
        check("R10 done on stop", 32'(done_cnt - d0), 32'd1);
        check("R10 released after stop", 32'(sda_drive_low), 32'd0);

        // R11: repeated START in the middle of an address restarts reception.
        bus_start();
        bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
        bus_rstart();
        send_addr(A_LO, 1'b1, acked);
        check("R11 ack after repeated start", 32'(acked), 32'd1);
        begin
            logic [15:0] d;
            d0 = done_cnt;
            read_bytes(1'b1, d);
            bus_stop();
            half();
            check("R11 data after repeated start", 32'(d), 32'h5A3C);
            check("R11 done after repeated start", 32'(done_cnt - d0), 32'd1);
        end

        // Seeded random transfers.
        for (int n = 0; n < 30; n++) begin
            logic [6:0] a;
            int         pick;
            addr_sel  = 1'($urandom_range(0, 1));
            conv_busy = ($urandom_range(0, 3) == 0);
            result    = 16'($urandom);
            pick      = $urandom_range(0, 5);
            a = (pick < 4) ? (addr_sel ? A_HI : A_LO)
              : (pick == 4) ? (addr_sel ? A_LO : A_HI) : 7'($urandom);
            read_txn("R3 R4 R5 R6 R8 random", a, ($urandom_range(0, 7) != 0),
                     ($urandom_range(0, 4) != 0), 1'b0, 1'b0);
        end

        check("R9 single-cycle done pulses", 32'(wide_cnt), 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule